// File: doc/BRIEF.md
# Latched Second-Level Interrupt Aggregator

This block gathers 32 peripheral interrupt lines into a single summary request for a parent interrupt controller. Software reaches it through a small single-cycle register port (address, write strobe, write data, read strobe, read data). Each source owns one bit, bit i standing for source i, in every register. A source can be disabled through a mask. The summary output rises whenever any pending, unmasked source exists.

A build-time parameter picks one of two variants. In the edge variant a rising input edge sets a sticky pending bit, and software removes it by writing ones to a clear register. In the level variant the pending bits are simply the live input levels, and no clear register exists. In both variants the mask is never written directly. Ones written to a disable register set mask bits, ones written to an enable register clear them, and a separate read-only register shows the current mask.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0 and `irq_o` is 0.
- R2: Edge variant (EDGE_MODE=1) byte offsets: pending at 0x00, clear at 0x08, mask readback at 0x0C, disable at 0x10, enable at 0x14.
- R3: Level variant (EDGE_MODE=0) byte offsets: pending at 0x00, mask readback at 0x04, disable at 0x08, enable at 0x0C. No clear register is decoded.
- R4: A write to the disable register sets each mask bit whose data bit is 1. A write to the enable register clears each mask bit whose data bit is 1. Mask bits under data bits of 0 keep their value.
- R5: `irq_o` is a register. Its value equals the OR over all bits of (pending AND NOT mask) as they stood in the previous cycle.
- R6: Edge variant: a 0-to-1 change of a source input sets its pending bit on the following clock edge, whether or not the source is masked. The bit then stays set after the input falls.
- R7: Edge variant: writing 1 to a bit of the clear register clears that pending bit, and 0 bits have no effect. If a new rising edge of the same source arrives in the cycle of the clear, the bit stays set.
- R8: Level variant: the pending bits follow the present input levels with no latching.
- R9: `rdata_o` is 0 when `re_i` is low. A read of the clear, disable or enable register, or of any unmapped offset, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Peripheral interrupt inputs |
| addr_i | input | AW | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | NSRC | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | NSRC | Read data, combinational from address |
| irq_o | output | 1 | Summary interrupt to the parent controller |

## Verification
The bench raises an edge while its source is still masked. A design that gated latching with the mask would lose that event, and unmasking would not raise `irq_o`. It drives a new rising edge in the same cycle as a clear of that bit. A design that let the clear win would drop a genuine second event. It checks that an input still held high after a clear does not set the bit again, which catches level-sensitive latching in the edge variant. In the level variant it lets a source fall and expects both the pending bit and `irq_o` to follow. It also checks that disable writes with zero bits leave the mask alone and that write-only offsets read as zero, which would expose a direct mask write or a leaky read multiplexer.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC      = 32,
  parameter int AW        = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            re_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CLR  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_MASK = EDGE_MODE ? AW'(8'h0C) : AW'(8'h04);
  localparam logic [AW-1:0] OFS_SET  = EDGE_MODE ? AW'(8'h10) : AW'(8'h08);
  localparam logic [AW-1:0] OFS_REL  = EDGE_MODE ? AW'(8'h14) : AW'(8'h0C);

  logic [NSRC-1:0] status, mask_q;
  logic            irq_q;

  wire hit_set = we_i && (addr_i == OFS_SET);
  wire hit_rel = we_i && (addr_i == OFS_REL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '1;
    else if (hit_set) mask_q <= mask_q | wdata_i;
    else if (hit_rel) mask_q <= mask_q & ~wdata_i;

  generate
    if (EDGE_MODE) begin : g_edge
      logic [NSRC-1:0] src_q, stat_q;
      wire             hit_clr = we_i && (addr_i == OFS_CLR);
      wire [NSRC-1:0]  rise    = src_i & ~src_q;
      wire [NSRC-1:0]  wipe    = hit_clr ? wdata_i : '0;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          src_q  <= '0;
          stat_q <= '0;
        end else begin
          src_q  <= src_i;
          stat_q <= (stat_q & ~wipe) | rise;
        end

      assign status = stat_q;
    end else begin : g_level
      assign status = src_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & ~mask_q);

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (addr_i == OFS_STAT)      rdata_o = status;
      else if (addr_i == OFS_MASK) rdata_o = mask_q;
    end
  end
endmodule

module irq_aggregator_chk #(
  parameter int NSRC      = 32,
  parameter int AW        = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic [AW-1:0]   addr_i,
  input logic            we_i,
  input logic [NSRC-1:0] wdata_i,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] mask_q,
  input logic            irq_o
);
  localparam logic [AW-1:0] C_SET = EDGE_MODE ? AW'(8'h10) : AW'(8'h08);
  localparam logic [AW-1:0] C_REL = EDGE_MODE ? AW'(8'h14) : AW'(8'h0C);

  logic [NSRC-1:0] src_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_d <= '0;
    else        src_d <= src_i;

  AST_RESET_MASK: assert property (@(posedge clk) $rose(rst_n) |-> (&mask_q && status == '0 || !EDGE_MODE)); // R1
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) irq_o == $past(|(status & ~mask_q))); // R5
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n) (we_i && addr_i == C_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R4
  AST_MASK_REL: assert property (@(posedge clk) disable iff (!rst_n) (we_i && addr_i == C_REL) |=> ((mask_q & $past(wdata_i)) == '0)); // R4

  generate
    if (EDGE_MODE) begin : g_e
      AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((status & $past(src_i & ~src_d)) == $past(src_i & ~src_d))); // R6
    end else begin : g_l
      AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n) status == src_i); // R8
    end
  endgenerate
endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC), .AW(AW), .EDGE_MODE(EDGE_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .status(status), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] src_e = '0, src_l = '0, wd_e = '0, wd_l = '0;
  logic [7:0]  ad_e = '0, ad_l = '0;
  logic        we_e = 0, we_l = 0, re_e = 0, re_l = 0;
  logic [31:0] rd_e, rd_l;
  logic        irq_e, irq_l;

  irq_aggregator #(.EDGE_MODE(1'b1)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src_e), .addr_i(ad_e), .we_i(we_e),
    .wdata_i(wd_e), .re_i(re_e), .rdata_o(rd_e), .irq_o(irq_e));

  irq_aggregator #(.EDGE_MODE(1'b0)) i_irq_aggregator_lvl (
    .clk(clk), .rst_n(rst_n), .src_i(src_l), .addr_i(ad_l), .we_i(we_l),
    .wdata_i(wd_l), .re_i(re_l), .rdata_o(rd_l), .irq_o(irq_l));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  logic  smp = 0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  always @(negedge clk) begin
    #5;
    if (smp && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = rd_e;
        1: act = rd_l;
        2: act = {31'd0, irq_e};
        default: act = {31'd0, irq_l};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input bit t, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (t) begin we_l = 1; ad_l = a; wd_l = d; end
    else   begin we_e = 1; ad_e = a; wd_e = d; end
    @(negedge clk);
    we_e = 0; we_l = 0;
  endtask

  task automatic rd(input bit t, input logic [7:0] a, input bit re, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    if (t) begin re_l = re; ad_l = a; end
    else   begin re_e = re; ad_e = a; end
    it.kind = t ? 1 : 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    smp = 1;
    @(negedge clk);
    smp = 0; re_e = 0; re_l = 0;
  endtask

  task automatic chk_irq(input bit t, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = t ? 3 : 2; it.exp = {31'd0, e}; it.tag = tag;
    sb.push_back(it);
    smp = 1;
    @(negedge clk);
    smp = 0;
  endtask

  task automatic drive_src(input bit t, input logic [31:0] v);
    @(negedge clk);
    if (t) src_l = v; else src_e = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // edge variant
    rd(0, 8'h0C, 1, 32'hFFFF_FFFF, "R1 mask after reset");
    rd(0, 8'h00, 1, 32'h0, "R1 pending after reset");
    chk_irq(0, 0, "R1 irq after reset");
    drive_src(0, 32'h8);
    rd(0, 8'h00, 1, 32'h8, "R6 masked edge latched");
    chk_irq(0, 0, "R5 masked source quiet");
    wr(0, 8'h14, 32'h8);
    chk_irq(0, 1, "R5 irq after enable");
    rd(0, 8'h0C, 1, 32'hFFFF_FFF7, "R4 enable clears bit");
    wr(0, 8'h10, 32'h8);
    chk_irq(0, 0, "R5 irq after disable");
    rd(0, 8'h0C, 1, 32'hFFFF_FFFF, "R4 disable sets bit");
    drive_src(0, 32'h0);
    rd(0, 8'h00, 1, 32'h8, "R6 sticky after input falls");
    drive_src(0, 32'h8);
    wr(0, 8'h08, 32'h8);
    rd(0, 8'h00, 1, 32'h0, "R7 clear with input held high");
    drive_src(0, 32'h20);
    drive_src(0, 32'h0);
    @(negedge clk);
    src_e = 32'h20; we_e = 1; ad_e = 8'h08; wd_e = 32'h20;
    @(negedge clk);
    we_e = 0;
    rd(0, 8'h00, 1, 32'h20, "R7 new edge beats clear");
    wr(0, 8'h08, 32'h1);
    rd(0, 8'h00, 1, 32'h20, "R7 zero bits keep pending");
    rd(0, 8'h08, 1, 32'h0, "R9 clear reads zero");
    rd(0, 8'h10, 1, 32'h0, "R9 disable reads zero");
    rd(0, 8'h14, 1, 32'h0, "R9 enable reads zero");
    rd(0, 8'h04, 1, 32'h0, "R2 offset 0x04 unmapped");
    rd(0, 8'h00, 0, 32'h0, "R9 idle read strobe");
    // level variant
    rd(1, 8'h04, 1, 32'hFFFF_FFFF, "R3 R1 level mask readback");
    drive_src(1, 32'h3);
    rd(1, 8'h00, 1, 32'h3, "R8 live levels");
    wr(1, 8'h0C, 32'h1);
    chk_irq(1, 1, "R5 level irq");
    rd(1, 8'h04, 1, 32'hFFFF_FFFE, "R3 level enable at 0x0C");
    drive_src(1, 32'h2);
    rd(1, 8'h00, 1, 32'h2, "R8 level follows fall");
    chk_irq(1, 0, "R8 irq drops with level");
    wr(1, 8'h08, 32'h0);
    rd(1, 8'h04, 1, 32'hFFFF_FFFE, "R4 zero data keeps mask");
    wr(1, 8'h08, 32'h1);
    rd(1, 8'h04, 1, 32'hFFFF_FFFF, "R3 level disable at 0x08");
    rd(1, 8'h10, 1, 32'h0, "R9 level unmapped");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule